// File: doc/BRIEF.md
# Receive Timestamp Matching Table

This block holds hardware receive timestamps that have already been decoded, until the timing packet they belong to reaches the host path. Each slot keeps a 4-bit message type, a 16-bit sequence number, a 12-bit hash, a 64-bit nanosecond time and an expiry tick. A producer inserts a timestamp as seconds and nanoseconds. The table converts this to one nanosecond count when it stores the slot. A consumer presents the message type and sequence number of a received packet. One cycle later it gets the stored time and hash of the matching slot, or a miss.

The table does not overwrite old data. A timestamp that arrives while every slot is live is dropped. A slot is freed when it matches, so each timestamp is delivered at most once. A slot is also freed once its lifetime has run out. Lifetime is counted in pulses of a coarse tick input, and the expiry comparison stays correct when the tick counter wraps. When several live slots hold the same key, the one inserted first is returned.

Top module: `rx_stamp_table`

## Requirements
- R1: After reset no slot is live: `res_valid`, `res_hit`, `res_time` and `res_hash` are 0, and any lookup misses.
- R2: A lookup hits only when both the 4-bit type and the 16-bit sequence number equal those of a live slot. Equal type with a different sequence number misses, and so does equal sequence number with a different type.
- R3: A slot that produced a hit is released at that same edge, so a second lookup with the same key misses.
- R4: A slot inserted while the tick counter is T is live while the counter is T, T+1 or T+2 (`LIFE`=2). After the third tick pulse it no longer matches.
- R5: An insert that finds no free slot is discarded. The `DEPTH` slots already live are unaffected.
- R6: When several live slots match one lookup, the slot inserted earliest is returned and released. The others stay live.
- R7: A lookup that misses returns `res_hit`=0, `res_time`=0 and `res_hash`=0.
- R8: Expiry uses the signed difference of the `TICK_W`-bit counter, so a slot inserted shortly before the counter wraps keeps its full lifetime across the wrap.
- R9: A slot freed by a hit or by expiry can take a new insert. After expiry a full table accepts `DEPTH` new entries.
- R10: A lookup in the same cycle as an insert sees the table as it was before that insert.
- R11: `res_valid` is 1 in exactly the cycle after `lk_valid` was sampled high, and 0 otherwise.
- R12: The returned time equals seconds × 1,000,000,000 + nanoseconds of the insert. The returned hash is the inserted hash.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Advances the lifetime counter by one |
| ins_valid | input | 1 | Insert request |
| ins_type | input | 4 | Message type of the timestamp |
| ins_seq | input | 16 | Sequence number of the timestamp |
| ins_hash | input | 12 | Hash stored with the timestamp |
| ins_sec | input | 32 | Seconds part of the timestamp |
| ins_nsec | input | 30 | Nanoseconds part of the timestamp |
| lk_valid | input | 1 | Lookup request |
| lk_type | input | 4 | Message type of the received packet |
| lk_seq | input | 16 | Sequence number of the received packet |
| res_valid | output | 1 | Lookup result present |
| res_hit | output | 1 | A live slot matched |
| res_time | output | 64 | Matched time in nanoseconds, 0 on a miss |
| res_hash | output | 12 | Matched hash, 0 on a miss |

## Verification
Every result of a lookup is registered once. It appears on `res_valid`, `res_hit`, `res_time` and `res_hash` just after the clock edge that sampled `lk_valid`. The release of the hit slot happens at that same edge. An insert is visible to a lookup from the following edge. A tick changes liveness from the edge after it. The bench drives each stimulus for one cycle from the falling edge. It reads the outputs shortly after the rising edge that consumed the stimulus. Ticks, inserts and lookups go in separate cycles, except in the deliberate same-cycle case, so the expected hit or miss follows directly from the tick count that the bench keeps.

// File: rtl/stamp_tbl_pkg.sv
package stamp_tbl_pkg;
   localparam logic [63:0] NS_PER_SEC = 64'd1_000_000_000;
   localparam int unsigned TYPE_W = 4;
   localparam int unsigned SEQ_W  = 16;
endpackage

// File: rtl/stamp_free_pick.sv
module stamp_free_pick #(
   parameter int unsigned N = 8
) (
   input  logic         req,
   input  logic [N-1:0] free_vec,
   output logic [N-1:0] grant
);
   // lowest-index free slot, isolated by two's complement
   assign grant = req ? (free_vec & (~free_vec + N'(1))) : '0;
endmodule

// File: rtl/stamp_age_order.sv
module stamp_age_order #(
   parameter int unsigned N = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] ins_oh,
   input  logic [N-1:0] hit_vec,
   output logic [N-1:0] win_oh
);
   // older_q[a][b] set: slot a was written before slot b
   logic [N-1:0][N-1:0] older_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         older_q <= '0;
      end else begin
         for (int k = 0; k < N; k++) begin
            if (ins_oh[k]) begin
               for (int j = 0; j < N; j++) begin
                  if (j != k) begin
                     older_q[k][j] <= 1'b0;
                     older_q[j][k] <= 1'b1;
                  end
               end
            end
         end
      end
   end

   always_comb begin
      for (int i = 0; i < N; i++) begin
         logic blocked;
         blocked = 1'b0;
         for (int j = 0; j < N; j++) begin
            if (hit_vec[j] && older_q[j][i]) blocked = 1'b1;
         end
         win_oh[i] = hit_vec[i] && !blocked;
      end
   end
endmodule

// File: rtl/rx_stamp_table.sv
module rx_stamp_table #(
   parameter int unsigned DEPTH  = 8,
   parameter int unsigned HASH_W = 12,
   parameter int unsigned SEC_W  = 32,
   parameter int unsigned NSEC_W = 30,
   parameter int unsigned TS_W   = 64,
   parameter int unsigned TICK_W = 16,
   parameter int unsigned LIFE   = 2
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               tick,
   input  logic                               ins_valid,
   input  logic [stamp_tbl_pkg::TYPE_W-1:0]   ins_type,
   input  logic [stamp_tbl_pkg::SEQ_W-1:0]    ins_seq,
   input  logic [HASH_W-1:0]                  ins_hash,
   input  logic [SEC_W-1:0]                   ins_sec,
   input  logic [NSEC_W-1:0]                  ins_nsec,
   input  logic                               lk_valid,
   input  logic [stamp_tbl_pkg::TYPE_W-1:0]   lk_type,
   input  logic [stamp_tbl_pkg::SEQ_W-1:0]    lk_seq,
   output logic                               res_valid,
   output logic                               res_hit,
   output logic [TS_W-1:0]                    res_time,
   output logic [HASH_W-1:0]                  res_hash
);
   import stamp_tbl_pkg::*;

   localparam int unsigned HALF_RANGE = 1 << (TICK_W - 1);

   initial begin : elab_checks
      assert (DEPTH >= 2) else $fatal(1, "DEPTH must be at least 2");
      assert (LIFE < HALF_RANGE) else $fatal(1, "LIFE must be below half the tick range");
      assert (TS_W >= SEC_W + NSEC_W) else $fatal(1, "TS_W too narrow for the time product");
   end

   logic [TICK_W-1:0] now_q;
   logic [DEPTH-1:0]  valid_q;
   logic [TYPE_W-1:0] type_q [DEPTH];
   logic [SEQ_W-1:0]  seq_q  [DEPTH];
   logic [HASH_W-1:0] hash_q [DEPTH];
   logic [TS_W-1:0]   time_q [DEPTH];
   logic [TICK_W-1:0] exp_q  [DEPTH];

   logic [DEPTH-1:0]  live_vec, hit_vec, win_vec, grant_vec;
   logic [TS_W-1:0]   ins_time;
   logic [TS_W-1:0]   sel_time;
   logic [HASH_W-1:0] sel_hash;

   assign ins_time = TS_W'(ins_sec) * TS_W'(NS_PER_SEC) + TS_W'(ins_nsec);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) now_q <= '0;
      else if (tick) now_q <= now_q + TICK_W'(1);
   end

   for (genvar g = 0; g < DEPTH; g++) begin : g_entry
      logic signed [TICK_W-1:0] age;
      assign age         = $signed(now_q - exp_q[g]);
      assign live_vec[g] = valid_q[g] && (age <= $signed(TICK_W'(0)));
      assign hit_vec[g]  = lk_valid && live_vec[g] &&
                           (type_q[g] == lk_type) && (seq_q[g] == lk_seq);
   end

   stamp_free_pick #(.N(DEPTH)) u_pick (
      .req      (ins_valid),
      .free_vec (~live_vec),
      .grant    (grant_vec)
   );

   stamp_age_order #(.N(DEPTH)) u_order (
      .clk     (clk),
      .rst_n   (rst_n),
      .ins_oh  (grant_vec),
      .hit_vec (hit_vec),
      .win_oh  (win_vec)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= '0;
         for (int i = 0; i < DEPTH; i++) begin
            type_q[i] <= '0;
            seq_q[i]  <= '0;
            hash_q[i] <= '0;
            time_q[i] <= '0;
            exp_q[i]  <= '0;
         end
      end else begin
         for (int i = 0; i < DEPTH; i++) begin
            if (grant_vec[i]) begin
               valid_q[i] <= 1'b1;
               type_q[i]  <= ins_type;
               seq_q[i]   <= ins_seq;
               hash_q[i]  <= ins_hash;
               time_q[i]  <= ins_time;
               exp_q[i]   <= now_q + TICK_W'(LIFE);
            end else if (win_vec[i] || !live_vec[i]) begin
               valid_q[i] <= 1'b0;
            end
         end
      end
   end

   always_comb begin
      sel_time = '0;
      sel_hash = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (win_vec[i]) begin
            sel_time = sel_time | time_q[i];
            sel_hash = sel_hash | hash_q[i];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid <= 1'b0;
         res_hit   <= 1'b0;
         res_time  <= '0;
         res_hash  <= '0;
      end else begin
         res_valid <= lk_valid;
         res_hit   <= |win_vec;
         res_time  <= sel_time;
         res_hash  <= sel_hash;
      end
   end
endmodule

// File: rtl/stamp_table_chk.sv
module stamp_table_chk #(
   parameter int unsigned DEPTH  = 8,
   parameter int unsigned TICK_W = 16,
   parameter int unsigned TS_W   = 64,
   parameter int unsigned HASH_W = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick,
   input logic              lk_valid,
   input logic              res_valid,
   input logic              res_hit,
   input logic [TS_W-1:0]   res_time,
   input logic [HASH_W-1:0] res_hash,
   input logic [DEPTH-1:0]  grant,
   input logic [DEPTH-1:0]  win,
   input logic [DEPTH-1:0]  hit_vec,
   input logic [TICK_W-1:0] now
);
   AST_RES_AFTER_LOOKUP: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |=> res_valid); // R11
   AST_NO_RES_WITHOUT_LOOKUP: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_valid |=> !res_valid); // R11
   AST_HIT_HAS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      res_hit |-> res_valid); // R2
   AST_MISS_IS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && !res_hit) |-> (res_time == '0 && res_hash == '0)); // R7
   AST_ONE_SLOT_WRITTEN: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant)); // R5
   AST_ONE_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(win)); // R6
   AST_WINNER_MATCHES: assert property (@(posedge clk) disable iff (!rst_n)
      (win & ~hit_vec) == '0); // R6
   AST_WINNER_EXISTS: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_vec != '0) |-> (win != '0)); // R6
   AST_TICK_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> now == TICK_W'($past(now) + TICK_W'(1))); // R8
endmodule

bind rx_stamp_table stamp_table_chk #(
   .DEPTH(DEPTH), .TICK_W(TICK_W), .TS_W(TS_W), .HASH_W(HASH_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .tick(tick), .lk_valid(lk_valid),
   .res_valid(res_valid), .res_hit(res_hit), .res_time(res_time),
   .res_hash(res_hash), .grant(grant_vec), .win(win_vec),
   .hit_vec(hit_vec), .now(now_q)
);

// File: tb/test_rx_stamp_table.sv
module test_rx_stamp_table;
   localparam int unsigned DEPTH  = 4;
   localparam int unsigned TICK_W = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0;
   logic        ins_valid = 1'b0;
   logic [3:0]  ins_type = '0;
   logic [15:0] ins_seq = '0;
   logic [11:0] ins_hash = '0;
   logic [31:0] ins_sec = '0;
   logic [29:0] ins_nsec = '0;
   logic        lk_valid = 1'b0;
   logic [3:0]  lk_type = '0;
   logic [15:0] lk_seq = '0;
   logic        res_valid, res_hit;
   logic [63:0] res_time;
   logic [11:0] res_hash;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #2 clk = ~clk;

   rx_stamp_table #(.DEPTH(DEPTH), .TICK_W(TICK_W)) i_rx_stamp_table (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .ins_valid(ins_valid), .ins_type(ins_type), .ins_seq(ins_seq),
      .ins_hash(ins_hash), .ins_sec(ins_sec), .ins_nsec(ins_nsec),
      .lk_valid(lk_valid), .lk_type(lk_type), .lk_seq(lk_seq),
      .res_valid(res_valid), .res_hit(res_hit),
      .res_time(res_time), .res_hash(res_hash)
   );

   function automatic logic [63:0] ns_of(input logic [31:0] s, input logic [29:0] n);
      return 64'(s) * 64'd1000000000 + 64'(n);
   endfunction

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic op(input bit ie, input logic [3:0] it, input logic [15:0] is,
                     input logic [11:0] ih, input logic [31:0] s, input logic [29:0] n,
                     input bit le, input logic [3:0] lt, input logic [15:0] ls, input bit tk);
      @(negedge clk);
      ins_valid = ie; ins_type = it; ins_seq = is; ins_hash = ih;
      ins_sec = s; ins_nsec = n;
      lk_valid = le; lk_type = lt; lk_seq = ls; tick = tk;
      @(posedge clk);
      #1;
      ins_valid = 0; lk_valid = 0; tick = 0;
   endtask

   task automatic ins(input logic [3:0] t, input logic [15:0] s, input logic [11:0] h,
                      input logic [31:0] sec, input logic [29:0] n);
      op(1, t, s, h, sec, n, 0, '0, '0, 0);
   endtask

   task automatic tck();
      op(0, '0, '0, '0, '0, '0, 0, '0, '0, 1);
   endtask

   task automatic look(input string tag, input logic [3:0] t, input logic [15:0] s,
                       input bit eh, input logic [63:0] et, input logic [11:0] ehash);
      op(0, '0, '0, '0, '0, '0, 1, t, s, 0);
      chk({tag, " valid"}, 64'(res_valid), 64'd1);
      chk({tag, " hit"},   64'(res_hit),   64'(eh));
      chk({tag, " time"},  res_time, eh ? et : 64'd0);
      chk({tag, " hash"},  64'(res_hash), eh ? 64'(ehash) : 64'd0);
   endtask

   initial begin : watchdog
      #(4 * 150000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin : main
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R1: reset state
      chk("R1 res_valid", 64'(res_valid), 0);
      chk("R1 res_hit", 64'(res_hit), 0);
      chk("R1 res_time", res_time, 0);
      look("R1 empty lookup", 4'd0, 16'd0, 0, 0, 0);

      // R2, R7, R12: key equality and time conversion
      for (int t = 0; t < 16; t++) begin
         logic [15:0] s;
         logic [31:0] sec;
         logic [29:0] n;
         s = 16'(16'h1234 + t * 16'h0101);
         sec = 32'(t * 100003 + 5);
         n = 30'(999_999_999 - t * 7);
         ins(4'(t), s, 12'(12'hA00 + t), sec, n);
         look("R2 type mismatch R7", 4'(t ^ 1), s, 0, 0, 0);
         look("R2 seq mismatch R7", 4'(t), s ^ 16'(1 << t), 0, 0, 0);
         look("R12 R2 exact hit", 4'(t), s, 1, ns_of(sec, n), 12'(12'hA00 + t));
         // R3: released on hit
         look("R3 second lookup", 4'(t), s, 0, 0, 0);
      end
      // R12: largest seconds value
      ins(4'd9, 16'hFFFF, 12'hFFF, 32'hFFFF_FFFF, 30'd999_999_999);
      look("R12 max seconds", 4'd9, 16'hFFFF, 1, ns_of(32'hFFFF_FFFF, 30'd999_999_999), 12'hFFF);

      // R11: no result without lookup
      op(0, '0, '0, '0, '0, '0, 0, '0, '0, 0);
      chk("R11 idle res_valid", 64'(res_valid), 0);

      // R5: full table drops the next insert
      for (int k = 0; k < DEPTH; k++) ins(4'(k), 16'(100 + k), 12'(k), 32'(k + 1), 30'(k));
      ins(4'd7, 16'd200, 12'h777, 32'd9, 30'd9);
      look("R5 dropped insert", 4'd7, 16'd200, 0, 0, 0);
      for (int k = DEPTH - 1; k >= 0; k--)
         look("R5 kept entry", 4'(k), 16'(100 + k), 1, ns_of(32'(k + 1), 30'(k)), 12'(k));

      // R9: slots freed by hits are reused
      for (int k = 0; k < DEPTH; k++) ins(4'(k + 8), 16'(300 + k), 12'(k + 16), 32'(k + 40), 30'(k));
      for (int k = 0; k < DEPTH; k++)
         look("R9 reuse after hit", 4'(k + 8), 16'(300 + k), 1, ns_of(32'(k + 40), 30'(k)), 12'(k + 16));

      // R6: oldest duplicate wins
      ins(4'd5, 16'd55, 12'h001, 32'd1, 30'd10);
      ins(4'd5, 16'd55, 12'h002, 32'd2, 30'd20);
      ins(4'd5, 16'd55, 12'h003, 32'd3, 30'd30);
      look("R6 oldest first", 4'd5, 16'd55, 1, ns_of(32'd1, 30'd10), 12'h001);
      look("R6 then second", 4'd5, 16'd55, 1, ns_of(32'd2, 30'd20), 12'h002);
      look("R6 then third", 4'd5, 16'd55, 1, ns_of(32'd3, 30'd30), 12'h003);
      look("R6 then empty", 4'd5, 16'd55, 0, 0, 0);

      // R10: same-cycle insert and lookup
      op(1, 4'd6, 16'd66, 12'h066, 32'd6, 30'd6, 1, 4'd6, 16'd66, 0);
      chk("R10 same cycle hit", 64'(res_hit), 0);
      chk("R10 same cycle valid", 64'(res_valid), 1);
      look("R10 next cycle", 4'd6, 16'd66, 1, ns_of(32'd6, 30'd6), 12'h066);

      // R4, R8: lifetime sweep; ticks accumulate across the 4-bit wrap
      for (int r = 0; r < 4; r++) begin
         for (int d = 0; d < 5; d++) begin
            ins(4'(d), 16'(r * 8 + d), 12'(r * 8 + d), 32'(r), 30'(d));
            repeat (d) tck();
            look("R4 R8 lifetime", 4'(d), 16'(r * 8 + d), d <= 2,
                 ns_of(32'(r), 30'(d)), 12'(r * 8 + d));
         end
      end

      // R9: expiry frees a full table
      for (int k = 0; k < DEPTH; k++) ins(4'(k), 16'(500 + k), 12'(k), 32'(k), 30'(k));
      repeat (3) tck();
      for (int k = 0; k < DEPTH; k++) ins(4'(k), 16'(600 + k), 12'(k + 32), 32'(k + 7), 30'(k));
      look("R9 expired gone", 4'd0, 16'd500, 0, 0, 0);
      for (int k = 0; k < DEPTH; k++)
         look("R9 reuse after expiry", 4'(k), 16'(600 + k), 1, ns_of(32'(k + 7), 30'(k)), 12'(k + 32));

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule